// File: doc/BRIEF.md
# PCI Configuration Mechanism #1 Shim for One I/O Function

This block answers PCI configuration cycles issued through port I/O for one fixed device function. Software first writes a 32-bit selector to the address port at 0xCF8. That selector names a bus, a device, a function and a dword register. Software then reads or writes the selected dword through the data port at 0xCFC. If the selector is disabled, or names any other function, reads of the data port float high and writes are dropped.

The emulated function holds a read-only identity, a class/revision dword and a command register. The only writable command bits are I/O-space enable and bus-master enable. It also holds a bus-master I/O BAR at config offset 0x20, which describes a 16-byte port window. Two registered outputs carry the I/O-enable bit and the programmed window base. The surrounding port decoder combines them into a chip-select for the bus-master register block: the select is live only when enabled and only at the programmed base.

A read on either port returns its data one clock after the request, with a one-cycle valid pulse. Any port other than the two exact dword addresses is ignored.

Top module: `cfg_mech1_shim`

## Requirements
- R1: After synchronous reset the selector, command and BAR base are zero. `io_rvalid`, `bm_io_en` and `bm_io_base` are low.
- R2: A write to port 0xCF8 with all four lane enables set loads the selector. A read of 0xCF8 returns it with bits 1:0 forced to zero. A write to 0xCF8 with any lane enable clear leaves the selector unchanged.
- R3: The selector layout is: bit 31 enable, bits 23:16 bus, bits 15:11 device, bits 10:8 function, bits 7:2 dword index. When bit 31 is clear, or bus/device/function differ from the parameters, a read of 0xCFC returns 0xFFFFFFFF and a write to 0xCFC changes nothing.
- R4: Dword index 0 reads {DEVICE_ID, VENDOR_ID}, with the vendor ID in bits 15:0. Writes to it have no effect.
- R5: Dword index 1 holds the command register. Only bit 0 (I/O enable) and bit 2 (bus-master enable) are writable; every other bit reads as zero.
- R6: Dword index 8 (offset 0x20) is the I/O BAR. Bit 0 reads 1, bits 3:1 read 0, bits 31:16 read 0 and bits 15:4 are writable, so writing 0xFFFFFFFF reads back 0x0000FFF1.
- R7: A write to 0xCFC updates byte lane k (bits 8k+7:8k) only when `io_be[k]` is set.
- R8: A read request to 0xCF8 or 0xCFC produces `io_rvalid` for exactly the next cycle, with the data in `io_rdata`. Writes, and accesses to any other port, produce no `io_rvalid` and alter no state.
- R9: `bm_io_en` equals command bit 0 and `bm_io_base` equals the BAR bits 15:4 with bits 3:0 zero. Both take their new value on the clock edge that commits the write, and otherwise hold.
- R10: Dword index 2 reads the CLASS_REV parameter. Every other unimplemented index of the matching function reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_req | input | 1 | Port access strobe, one cycle per access |
| io_we | input | 1 | 1 = write (OUT), 0 = read (IN) |
| io_addr | input | 16 | Port address |
| io_be | input | 4 | Byte lane enables |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, valid with io_rvalid |
| io_rvalid | output | 1 | Read response pulse, one cycle after the request |
| bm_io_en | output | 1 | I/O-space decode enable from the command register |
| bm_io_base | output | 16 | Programmed base of the bus-master I/O window |

## Verification
The selector and the function registers can move in the same edge as a read response. A data write can also land in the cycle right before a read of the same dword. The bench provokes both with back-to-back accesses: a selector write immediately followed by a data-port read, and a BAR write immediately followed by a BAR read. It judges each response against a queue of values computed from the requirements at the moment the read was issued. It also probes disabled, mismatched and partial-lane writes and reads the state back to confirm nothing changed.

// File: rtl/cfg_mech1_pkg.sv
package cfg_mech1_pkg;

  localparam logic [15:0] PORT_SEL  = 16'hCF8;
  localparam logic [15:0] PORT_DATA = 16'hCFC;

  localparam int IDX_W = 6;
  localparam logic [IDX_W-1:0] IDX_IDENT = 6'd0;
  localparam logic [IDX_W-1:0] IDX_CMD   = 6'd1;
  localparam logic [IDX_W-1:0] IDX_CLASS = 6'd2;
  localparam logic [IDX_W-1:0] IDX_BAR   = 6'd8;

  typedef struct packed {
    logic sel_wr;
    logic sel_rd;
    logic dat_wr;
    logic dat_rd;
  } port_hit_t;

  typedef struct packed {
    logic       enable;
    logic [6:0] rsvd;
    logic [7:0] bus;
    logic [4:0] dev;
    logic [2:0] fn;
    logic [5:0] idx;
    logic [1:0] zero;
  } sel_word_t;

endpackage

// File: rtl/cfg_mech1_port_dec.sv
module cfg_mech1_port_dec
  import cfg_mech1_pkg::*;
(
  input  logic        io_req,
  input  logic        io_we,
  input  logic [15:0] io_addr,
  input  logic [3:0]  io_be,
  output port_hit_t   hit
);

  logic at_sel;
  logic at_dat;

  always_comb begin
    at_sel     = io_req && (io_addr == PORT_SEL);
    at_dat     = io_req && (io_addr == PORT_DATA);
    hit.sel_wr = at_sel && io_we && (io_be == 4'hF);
    hit.sel_rd = at_sel && !io_we;
    hit.dat_wr = at_dat && io_we;
    hit.dat_rd = at_dat && !io_we;
  end

endmodule

// File: rtl/cfg_mech1_addr_latch.sv
module cfg_mech1_addr_latch
  import cfg_mech1_pkg::*;
#(
  parameter logic [7:0] BUS_NUM  = 8'd0,
  parameter logic [4:0] DEV_NUM  = 5'd1,
  parameter logic [2:0] FUNC_NUM = 3'd1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [31:0]      wdata,
  output logic [31:0]      sel_q,
  output logic             fn_match,
  output logic [IDX_W-1:0] idx
);

  sel_word_t sel_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_r <= '0;
    end else if (load) begin
      sel_r      <= sel_word_t'(wdata);
      sel_r.zero <= 2'b00;
    end
  end

  always_comb begin
    sel_q    = sel_r;
    idx      = sel_r.idx;
    fn_match = sel_r.enable && (sel_r.bus == BUS_NUM) &&
               (sel_r.dev == DEV_NUM) && (sel_r.fn == FUNC_NUM);
  end

endmodule

// File: rtl/cfg_mech1_func_regs.sv
module cfg_mech1_func_regs
  import cfg_mech1_pkg::*;
#(
  parameter logic [15:0] VENDOR_ID     = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID     = 16'h7E11,
  parameter logic [31:0] CLASS_REV     = 32'h0101_8000,
  parameter int          IO_AW         = 16,
  parameter int          BAR_SIZE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] idx,
  input  logic [3:0]       be,
  input  logic [31:0]      wdata,
  output logic [31:0]      rd_word,
  output logic             cmd_io,
  output logic [IO_AW-1:0] bar_base
);

  localparam int                 LANES    = IO_AW / 8;
  localparam logic [IO_AW-1:0]   BAR_MASK = {IO_AW{1'b1}} << BAR_SIZE_LOG2;
  localparam int                 PAD_W    = 32 - IO_AW;

  logic             cmd_bm;
  logic [IO_AW-1:0] bar_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_io <= 1'b0;
      cmd_bm <= 1'b0;
    end else if (wr_en && idx == IDX_CMD && be[0]) begin
      cmd_io <= wdata[0];
      cmd_bm <= wdata[2];
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_bar_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        bar_q[g*8 +: 8] <= '0;
      end else if (wr_en && idx == IDX_BAR && be[g]) begin
        bar_q[g*8 +: 8] <= wdata[g*8 +: 8] & BAR_MASK[g*8 +: 8];
      end
    end
  end

  always_comb begin
    unique case (idx)
      IDX_IDENT: rd_word = {DEVICE_ID, VENDOR_ID};
      IDX_CMD:   rd_word = {16'h0000, 13'd0, cmd_bm, 1'b0, cmd_io};
      IDX_CLASS: rd_word = CLASS_REV;
      IDX_BAR:   rd_word = {{PAD_W{1'b0}}, bar_q | {{(IO_AW-1){1'b0}}, 1'b1}};
      default:   rd_word = 32'h0;
    endcase
    bar_base = bar_q;
  end

endmodule

// File: rtl/cfg_mech1_shim.sv
module cfg_mech1_shim
  import cfg_mech1_pkg::*;
#(
  parameter logic [7:0]  BUS_NUM       = 8'd0,
  parameter logic [4:0]  DEV_NUM       = 5'd1,
  parameter logic [2:0]  FUNC_NUM      = 3'd1,
  parameter logic [15:0] VENDOR_ID     = 16'hA5C3,
  parameter logic [15:0] DEVICE_ID     = 16'h7E11,
  parameter logic [31:0] CLASS_REV     = 32'h0101_8000,
  parameter int          IO_AW         = 16,
  parameter int          BAR_SIZE_LOG2 = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             io_req,
  input  logic             io_we,
  input  logic [15:0]      io_addr,
  input  logic [3:0]       io_be,
  input  logic [31:0]      io_wdata,
  output logic [31:0]      io_rdata,
  output logic             io_rvalid,
  output logic             bm_io_en,
  output logic [IO_AW-1:0] bm_io_base
);

  port_hit_t        hit;
  logic [31:0]      sel_q;
  logic             fn_match;
  logic [IDX_W-1:0] idx;
  logic [31:0]      fn_word;
  logic [31:0]      rd_next;

  cfg_mech1_port_dec u_dec (
    .io_req  (io_req),
    .io_we   (io_we),
    .io_addr (io_addr),
    .io_be   (io_be),
    .hit     (hit)
  );

  cfg_mech1_addr_latch #(
    .BUS_NUM  (BUS_NUM),
    .DEV_NUM  (DEV_NUM),
    .FUNC_NUM (FUNC_NUM)
  ) u_latch (
    .clk      (clk),
    .rst      (rst),
    .load     (hit.sel_wr),
    .wdata    (io_wdata),
    .sel_q    (sel_q),
    .fn_match (fn_match),
    .idx      (idx)
  );

  cfg_mech1_func_regs #(
    .VENDOR_ID     (VENDOR_ID),
    .DEVICE_ID     (DEVICE_ID),
    .CLASS_REV     (CLASS_REV),
    .IO_AW         (IO_AW),
    .BAR_SIZE_LOG2 (BAR_SIZE_LOG2)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (hit.dat_wr && fn_match),
    .idx      (idx),
    .be       (io_be),
    .wdata    (io_wdata),
    .rd_word  (fn_word),
    .cmd_io   (bm_io_en),
    .bar_base (bm_io_base)
  );

  always_comb begin
    if (hit.sel_rd)      rd_next = sel_q;
    else if (fn_match)   rd_next = fn_word;
    else                 rd_next = 32'hFFFF_FFFF;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      io_rvalid <= 1'b0;
      io_rdata  <= '0;
    end else begin
      io_rvalid <= hit.sel_rd || hit.dat_rd;
      if (hit.sel_rd || hit.dat_rd) io_rdata <= rd_next;
    end
  end

endmodule

// File: rtl/cfg_mech1_shim_chk.sv
module cfg_mech1_shim_chk #(
  parameter int IO_AW = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             io_req,
  input logic             io_we,
  input logic [15:0]      io_addr,
  input logic [3:0]       io_be,
  input logic             io_rvalid,
  input logic             bm_io_en,
  input logic [IO_AW-1:0] bm_io_base,
  input logic [31:0]      sel_q
);

  logic rd_hit;
  logic dat_wr;
  assign rd_hit = io_req && !io_we && (io_addr == 16'hCF8 || io_addr == 16'hCFC);
  assign dat_wr = io_req && io_we && io_addr == 16'hCFC;

  assert_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!io_rvalid && !bm_io_en && bm_io_base == '0));

  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> io_rvalid);

  assert_rd_only_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> !io_rvalid);

  assert_bm_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !dat_wr |=> ($stable(bm_io_en) && $stable(bm_io_base)));

  assert_disabled_write_R3: assert property (@(posedge clk) disable iff (rst)
    (dat_wr && !sel_q[31]) |=> ($stable(bm_io_en) && $stable(bm_io_base)));

  assert_partial_sel_R2: assert property (@(posedge clk) disable iff (rst)
    (io_req && io_we && io_addr == 16'hCF8 && io_be != 4'hF) |=> $stable(sel_q));

endmodule

bind cfg_mech1_shim cfg_mech1_shim_chk #(.IO_AW(IO_AW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .io_req     (io_req),
  .io_we      (io_we),
  .io_addr    (io_addr),
  .io_be      (io_be),
  .io_rvalid  (io_rvalid),
  .bm_io_en   (bm_io_en),
  .bm_io_base (bm_io_base),
  .sel_q      (sel_q)
);

// File: tb/cfg_mech1_shim_tb.sv
module cfg_mech1_shim_tb;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0]  BUS = 8'd0;
  localparam logic [4:0]  DEV = 5'd1;
  localparam logic [2:0]  FN  = 3'd1;
  localparam logic [15:0] VID = 16'hA5C3;
  localparam logic [15:0] DID = 16'h7E11;
  localparam logic [31:0] CRV = 32'h0101_8000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        io_req = 1'b0;
  logic        io_we = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        io_rvalid;
  logic        bm_io_en;
  logic [15:0] bm_io_base;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_mech1_shim u_dut (
    .clk(clk), .rst(rst), .io_req(io_req), .io_we(io_we), .io_addr(io_addr),
    .io_be(io_be), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .io_rvalid(io_rvalid), .bm_io_en(bm_io_en), .bm_io_base(bm_io_base)
  );

  function automatic logic [31:0] sel(input bit en, input logic [7:0] b,
                                      input logic [4:0] d, input logic [2:0] f,
                                      input logic [5:0] i);
    return {en, 7'd0, b, d, f, i, 2'b00};
  endfunction

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // monitor: pops expected read responses
  always @(negedge clk) begin
    if (!rst && io_rvalid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R8: actual unexpected rvalid data %h expected no response", io_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (io_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", t, io_rdata, e);
        end
      end
    end
  end

  task automatic idle();
    io_req = 1'b0; io_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d);
    io_req = 1'b1; io_we = 1'b1; io_addr = a; io_be = be; io_wdata = d;
    @(negedge clk);
    io_req = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, input logic [31:0] exp, input string rq);
    exp_q.push_back(exp);
    tag_q.push_back(rq);
    io_req = 1'b1; io_we = 1'b0; io_addr = a; io_be = 4'hF;
    @(negedge clk);
    io_req = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", {31'd0, io_rvalid}, 32'd0);
    chk("R1", {31'd0, bm_io_en}, 32'd0);
    chk("R1", {16'd0, bm_io_base}, 32'd0);
    rd(16'hCF8, 32'h0, "R1");
    // R3: enable clear at reset
    rd(16'hCFC, 32'hFFFF_FFFF, "R3");
    // R2: selector load, low bits read zero; back-to-back data read
    wr(16'hCF8, 4'hF, sel(1, BUS, DEV, FN, 6'd0) | 32'h3);
    rd(16'hCF8, sel(1, BUS, DEV, FN, 6'd0), "R2");
    rd(16'hCFC, {DID, VID}, "R4");
    // R2: partial write ignored
    wr(16'hCF8, 4'h3, 32'h0000_0808);
    rd(16'hCF8, sel(1, BUS, DEV, FN, 6'd0), "R2");
    // R4: identity read-only
    wr(16'hCFC, 4'hF, 32'hFFFF_FFFF);
    rd(16'hCFC, {DID, VID}, "R4");
    // R10
    wr(16'hCF8, 4'hF, sel(1, BUS, DEV, FN, 6'd2));
    rd(16'hCFC, CRV, "R10");
    wr(16'hCF8, 4'hF, sel(1, BUS, DEV, FN, 6'd15));
    rd(16'hCFC, 32'h0, "R10");
    // R5 command
    wr(16'hCF8, 4'hF, sel(1, BUS, DEV, FN, 6'd1));
    wr(16'hCFC, 4'hF, 32'hFFFF_FFFF);
    chk("R9", {31'd0, bm_io_en}, 32'd1);
    rd(16'hCFC, 32'h0000_0005, "R5");
    // R6 BAR sizing
    wr(16'hCF8, 4'hF, sel(1, BUS, DEV, FN, 6'd8));
    rd(16'hCFC, 32'h0000_0001, "R6");
    wr(16'hCFC, 4'hF, 32'hFFFF_FFFF);
    rd(16'hCFC, 32'h0000_FFF1, "R6");
    chk("R9", {16'd0, bm_io_base}, 32'h0000_FFF0);
    // R7 lane enables
    wr(16'hCFC, 4'h1, 32'h0000_C001);
    rd(16'hCFC, 32'h0000_FF01, "R7");
    chk("R9", {16'd0, bm_io_base}, 32'h0000_FF00);
    wr(16'hCFC, 4'hF, 32'h0000_C041);
    chk("R9", {16'd0, bm_io_base}, 32'h0000_C040);
    rd(16'hCFC, 32'h0000_C041, "R6");
    // R3: mismatched device
    wr(16'hCF8, 4'hF, sel(1, BUS, DEV + 5'd1, FN, 6'd8));
    rd(16'hCFC, 32'hFFFF_FFFF, "R3");
    wr(16'hCFC, 4'hF, 32'h0);
    chk("R3", {16'd0, bm_io_base}, 32'h0000_C040);
    // R3: enable bit clear with matching fields
    wr(16'hCF8, 4'hF, sel(0, BUS, DEV, FN, 6'd8));
    rd(16'hCFC, 32'hFFFF_FFFF, "R3");
    wr(16'hCFC, 4'hF, 32'h0);
    chk("R3", {16'd0, bm_io_base}, 32'h0000_C040);
    // R8: other ports ignored, no response
    io_req = 1'b1; io_we = 1'b0; io_addr = 16'hCF9; io_be = 4'hF;
    @(negedge clk);
    io_req = 1'b0;
    chk("R8", {31'd0, io_rvalid}, 32'd0);
    wr(16'hCFD, 4'hF, 32'h0);
    chk("R8", {16'd0, bm_io_base}, 32'h0000_C040);
    chk("R8", {31'd0, bm_io_en}, 32'd1);
    rd(16'hCF8, sel(0, BUS, DEV, FN, 6'd8), "R8");
    // R5/R9: command cleared
    wr(16'hCF8, 4'hF, sel(1, BUS, DEV, FN, 6'd1));
    wr(16'hCFC, 4'hF, 32'h0000_0004);
    chk("R9", {31'd0, bm_io_en}, 32'd0);
    rd(16'hCFC, 32'h0000_0004, "R5");
    idle();
    idle();
    chk("R8", exp_q.size(), 32'd0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule